// File: doc/BRIEF.md
# Banked GPIO Controller with Grouped Interrupts

This block is a general-purpose I/O controller with four banks of 32 pins, reached through a simple register bus. The bus has a byte address, separate write and read enables, write data and combinational read data. For each bank the controller holds these registers:

- a direction word
- an output level, driven through write-one-to-set and write-one-to-clear ports
- rising-edge and falling-edge enable masks
- a sticky edge-status word
- two alternate-function words

Pin inputs pass through a two-flop synchronizer. An edge detector compares the synchronized value with its previous sample, and any enabled transition sets a status bit. The edge-status bits drive three interrupt lines. Pin 0 of bank 0 has a line of its own, and so does pin 1 of bank 0. Every other pin shares the third line.

Software reads the current pin picture through the level register. For each bit it returns the driven output where the pin is an output, and the synchronized input where the pin is an input. Every read of the level register also produces a one-cycle notify pulse on a side-band output, so a neighbouring block can respond to the poll.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is held, and after it is released, every register is zero: pinOut, pinDir, all three interrupts and levelReadPulse are low, and every mapped register reads 0.
- R2: Addresses are byte offsets, and a word sits at register code × 0x10 + bank × 4. The register codes are: level 0, direction 1, set 2, clear 3, rise-enable 4, fall-enable 5, status 6, alternate-low 7, alternate-high 8. Direction, rise-enable, fall-enable and both alternate words read back the last value written. The direction word drives pinDir, where a 1 bit makes that pin an output.
- R3: Writing the set port ORs the write data into that bank's output level. Writing the clear port removes the 1 bits of the write data from the output level. Zero bits leave the output untouched. Reading the set port returns the value last written to it.
- R4: Reading the clear port returns the fixed constant 0x00007A69.
- R5: A level read returns (output AND direction) OR (synchronized input AND NOT direction) for the addressed bank.
- R6: When a pin has its rise-enable (or fall-enable) bit set and its input goes 0→1 (or 1→0) between two clock edges, its status bit reads 1 after the third rising clock edge following the input change. A pin whose enable bit is 0 never sets its status bit.
- R7: Status bits stay set until software writes a 1 to them. If an edge arrives in the same cycle as that clearing write, the bit stays set.
- R8: irqPin0 equals status bit 0 of bank 0, and irqPin1 equals status bit 1 of bank 0.
- R9: irqShared is high exactly when any status bit is set other than bits 0 and 1 of bank 0.
- R10: levelReadPulse is high for exactly the one cycle after each cycle in which a level register is read. Reads of any other register never raise it.
- R11: Any access that is not a mapped, word-aligned offset is ignored: writes change nothing and reads return 0. This covers offsets 0x200 and above, codes 9 to 15, and offsets with address bits 1:0 not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 10 | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe, captured on the rising edge |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from the address |
| pinIn | input | 128 | Asynchronous pin inputs, bank b at bits 32b+31..32b |
| pinOut | output | 128 | Output levels of all banks |
| pinDir | output | 128 | Direction of all pins, 1 = output |
| irqPin0 | output | 1 | Interrupt for bank 0 pin 0 |
| irqPin1 | output | 1 | Interrupt for bank 0 pin 1 |
| irqShared | output | 1 | Interrupt for all remaining pins |
| levelReadPulse | output | 1 | One-cycle pulse after a level read |

## Verification
The assertions rely on a few properties of the inputs. They assume the bus strobes and address carry known values once reset is released. They also assume that no state change happens without a bus write: only a write may move pinOut or pinDir, and only a write may drop a pending pin-0 interrupt. The bench drives every bus and pin input on the falling clock edge and returns the strobes to zero between accesses. Pin changes are spaced at least four cycles apart, so each edge passes through the synchronizer on its own. The one exception is the deliberate collision, where a clearing write lands on the same cycle as a new edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  parameter int unsigned GPIO_BANKS = 4;
  localparam int unsigned BANK_SEL_W = (GPIO_BANKS > 1) ? $clog2(GPIO_BANKS) : 1;

  // register codes; the code is address field [TYPE_LSB +: 4]
  typedef enum logic [3:0] {
    REG_LEVEL  = 4'd0,
    REG_DIR    = 4'd1,
    REG_SET    = 4'd2,
    REG_CLR    = 4'd3,
    REG_RISE   = 4'd4,
    REG_FALL   = 4'd5,
    REG_STAT   = 4'd6,
    REG_ALTLO  = 4'd7,
    REG_ALTHI  = 4'd8
  } regSel_e;

  typedef struct packed {
    logic                  wrDir;
    logic                  wrSet;
    logic                  wrClr;
    logic                  wrRise;
    logic                  wrFall;
    logic                  wrStat;
    logic                  wrAltLo;
    logic                  wrAltHi;
    logic                  rdValid;
    regSel_e               rdSel;
    logic [BANK_SEL_W-1:0] bank;
  } strobe_t;
endpackage

// File: rtl/gpio_bank_ctrl_decode.sv
module gpio_bank_ctrl_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobe_t           strobes,
  output logic              levelReadPulse
);
  localparam int unsigned TYPE_LSB = 2 + BANK_SEL_W;

  logic [3:0] typ;
  logic       hit;

  assign typ = busAddr[TYPE_LSB +: 4];
  assign hit = (busAddr[ADDR_W-1:TYPE_LSB+4] == '0) &&
               (busAddr[1:0] == 2'b00) &&
               (typ <= REG_ALTHI);

  always_comb begin
    strobes         = '0;
    strobes.bank    = busAddr[2 +: BANK_SEL_W];
    strobes.rdValid = busRdEn && hit;
    strobes.rdSel   = hit ? regSel_e'(typ) : REG_LEVEL;
    if (busWrEn && hit) begin
      strobes.wrDir   = (typ == REG_DIR);
      strobes.wrSet   = (typ == REG_SET);
      strobes.wrClr   = (typ == REG_CLR);
      strobes.wrRise  = (typ == REG_RISE);
      strobes.wrFall  = (typ == REG_FALL);
      strobes.wrStat  = (typ == REG_STAT);
      strobes.wrAltLo = (typ == REG_ALTLO);
      strobes.wrAltHi = (typ == REG_ALTHI);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelReadPulse <= 1'b0;
    else       levelReadPulse <= busRdEn && hit && (typ == REG_LEVEL);
  end
endmodule

// File: rtl/gpio_bank_ctrl_dp.sv
module gpio_bank_ctrl_dp
  import gpio_bank_pkg::*;
#(
  parameter int unsigned     BANK_W         = 32,
  parameter logic [BANK_W-1:0] CLR_READ_VALUE = BANK_W'(32'h0000_7A69)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strobes,
  input  logic [BANK_W-1:0]            wrData,
  input  logic [GPIO_BANKS*BANK_W-1:0] pinIn,
  output logic [BANK_W-1:0]            rdData,
  output logic [GPIO_BANKS*BANK_W-1:0] pinOut,
  output logic [GPIO_BANKS*BANK_W-1:0] pinDir,
  output logic                         irqPin0,
  output logic                         irqPin1,
  output logic                         irqShared
);
  localparam int unsigned NUM_PINS = GPIO_BANKS * BANK_W;

  logic [GPIO_BANKS-1:0][BANK_W-1:0] syncA, syncB, prevB;
  logic [GPIO_BANKS-1:0][BANK_W-1:0] dirW, outW, setW, riseW, fallW, statW, altLoW, altHiW, levelW;
  logic [NUM_PINS-1:0]               statFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar b = 0; b < GPIO_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] dirQ, outQ, setQ, riseQ, fallQ, statQ, altLoQ, altHiQ;
    logic [BANK_W-1:0] edgeHit, clrMask;
    logic              sel;

    assign sel     = (strobes.bank == BANK_SEL_W'(b));
    assign edgeHit = (syncB[b] & ~prevB[b] & riseQ) | (~syncB[b] & prevB[b] & fallQ);
    assign clrMask = (strobes.wrStat && sel) ? wrData : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirQ   <= '0;
        outQ   <= '0;
        setQ   <= '0;
        riseQ  <= '0;
        fallQ  <= '0;
        statQ  <= '0;
        altLoQ <= '0;
        altHiQ <= '0;
      end else begin
        if (sel && strobes.wrDir)   dirQ   <= wrData;
        if (sel && strobes.wrRise)  riseQ  <= wrData;
        if (sel && strobes.wrFall)  fallQ  <= wrData;
        if (sel && strobes.wrAltLo) altLoQ <= wrData;
        if (sel && strobes.wrAltHi) altHiQ <= wrData;
        if (sel && strobes.wrSet) begin
          outQ <= outQ | wrData;
          setQ <= wrData;
        end else if (sel && strobes.wrClr) begin
          outQ <= outQ & ~wrData;
        end
        statQ <= (statQ & ~clrMask) | edgeHit;
      end
    end

    assign dirW[b]   = dirQ;
    assign outW[b]   = outQ;
    assign setW[b]   = setQ;
    assign riseW[b]  = riseQ;
    assign fallW[b]  = fallQ;
    assign statW[b]  = statQ;
    assign altLoW[b] = altLoQ;
    assign altHiW[b] = altHiQ;
    assign levelW[b] = (outQ & dirQ) | (syncB[b] & ~dirQ);
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdValid) begin
      unique case (strobes.rdSel)
        REG_LEVEL: rdData = levelW[strobes.bank];
        REG_DIR:   rdData = dirW[strobes.bank];
        REG_SET:   rdData = setW[strobes.bank];
        REG_CLR:   rdData = CLR_READ_VALUE;
        REG_RISE:  rdData = riseW[strobes.bank];
        REG_FALL:  rdData = fallW[strobes.bank];
        REG_STAT:  rdData = statW[strobes.bank];
        REG_ALTLO: rdData = altLoW[strobes.bank];
        REG_ALTHI: rdData = altHiW[strobes.bank];
        default:   rdData = '0;
      endcase
    end
  end

  assign pinOut    = outW;
  assign pinDir    = dirW;
  assign statFlat  = statW;
  assign irqPin0   = statFlat[0];
  assign irqPin1   = statFlat[1];
  assign irqShared = |statFlat[NUM_PINS-1:2];
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BANK_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic                         busWrEn,
  input  logic                         busRdEn,
  input  logic [BANK_W-1:0]            busWrData,
  output logic [BANK_W-1:0]            busRdData,
  input  logic [GPIO_BANKS*BANK_W-1:0] pinIn,
  output logic [GPIO_BANKS*BANK_W-1:0] pinOut,
  output logic [GPIO_BANKS*BANK_W-1:0] pinDir,
  output logic                         irqPin0,
  output logic                         irqPin1,
  output logic                         irqShared,
  output logic                         levelReadPulse
);
  strobe_t strobes;

  gpio_bank_ctrl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk            (clk),
    .rstN           (rstN),
    .busAddr        (busAddr),
    .busWrEn        (busWrEn),
    .busRdEn        (busRdEn),
    .strobes        (strobes),
    .levelReadPulse (levelReadPulse)
  );

  gpio_bank_ctrl_dp #(.BANK_W(BANK_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (busWrData),
    .pinIn     (pinIn),
    .rdData    (busRdData),
    .pinOut    (pinOut),
    .pinDir    (pinDir),
    .irqPin0   (irqPin0),
    .irqPin1   (irqPin1),
    .irqShared (irqShared)
  );
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BANK_W = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [ADDR_W-1:0]            busAddr,
  input logic                         busWrEn,
  input logic                         busRdEn,
  input logic [BANK_W-1:0]            busRdData,
  input logic [GPIO_BANKS*BANK_W-1:0] pinOut,
  input logic [GPIO_BANKS*BANK_W-1:0] pinDir,
  input logic                         irqPin0,
  input logic                         levelReadPulse
);
  localparam int unsigned TYPE_LSB = 2 + BANK_SEL_W;

  logic levelRead;
  assign levelRead = busRdEn && (busAddr[ADDR_W-1:TYPE_LSB] == '0) && (busAddr[1:0] == 2'b00);

  // R10: a pulse is always caused by a level read in the previous cycle
  a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    levelReadPulse |-> $past(levelRead));

  // R10: without a new level read the pulse lasts one cycle
  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    (levelReadPulse && !levelRead) |=> !levelReadPulse);

  // R11: writes at or above 0x200 change no output state
  a_r11_high_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[ADDR_W-1]) |=> ($stable(pinOut) && $stable(pinDir)));

  // R11: reads at or above 0x200 return zero
  a_r11_high_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr[ADDR_W-1]) |-> (busRdData == '0));

  // R3: outputs and directions only move on a bus write
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(pinOut) && $stable(pinDir)));

  // R7: a pending status bit only drops through a write
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqPin0 && !busWrEn) |=> irqPin0);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .busAddr        (busAddr),
  .busWrEn        (busWrEn),
  .busRdEn        (busRdEn),
  .busRdData      (busRdData),
  .pinOut         (pinOut),
  .pinDir         (pinDir),
  .irqPin0        (irqPin0),
  .levelReadPulse (levelReadPulse)
);

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;
  localparam int ADDR_W = 10;
  localparam int BANK_W = 32;
  localparam int NPINS  = 4 * BANK_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [BANK_W-1:0] busWrData = '0;
  logic [BANK_W-1:0] busRdData;
  logic [NPINS-1:0]  pinIn = '0;
  logic [NPINS-1:0]  pinOut, pinDir;
  logic              irqPin0, irqPin1, irqShared, levelReadPulse;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinDir(pinDir), .irqPin0(irqPin0), .irqPin1(irqPin1), .irqShared(irqShared),
    .levelReadPulse(levelReadPulse)
  );

  // {address, write data, expected read}: write then read back
  localparam logic [73:0] VEC [10] = '{
    {10'h010, 32'hA5A5_0F0F, 32'hA5A5_0F0F},  // R2 direction bank 0
    {10'h044, 32'h1234_5678, 32'h1234_5678},  // R2 rise enable bank 1
    {10'h058, 32'h8000_0001, 32'h8000_0001},  // R2 fall enable bank 2
    {10'h07C, 32'hCAFE_F00D, 32'hCAFE_F00D},  // R2 alt low bank 3
    {10'h080, 32'h0BAD_BEEF, 32'h0BAD_BEEF},  // R2 alt high bank 0
    {10'h028, 32'h0000_FF00, 32'h0000_FF00},  // R3 set readback bank 2
    {10'h034, 32'hFFFF_FFFF, 32'h0000_7A69},  // R4 clear port constant
    {10'h090, 32'hFFFF_FFFF, 32'h0000_0000},  // R11 code 9 unmapped
    {10'h214, 32'hFFFF_FFFF, 32'h0000_0000},  // R11 above 0x200
    {10'h011, 32'hFFFF_FFFF, 32'h0000_0000}   // R11 misaligned
  };

  function automatic logic [ADDR_W-1:0] regAddr(input int code, input int bank);
    return ADDR_W'(code * 16 + bank * 4);
  endfunction

  task automatic check(input string req, input logic [BANK_W-1:0] act, input logic [BANK_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [BANK_W-1:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [BANK_W-1:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pinIn = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [BANK_W-1:0] rd;
    waitCycles(2);
    // R1: state while reset is held
    check("R1 pinOut in reset", pinOut[31:0] | pinOut[127:96], '0);
    check("R1 irq in reset", {29'b0, irqPin0, irqPin1, irqShared}, '0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < 10; i++) begin
      busWrite(VEC[i][73:64], VEC[i][63:32]);
      busRead(VEC[i][73:64], rd);
      check($sformatf("R2/R3/R4/R11 vector %0d", i), rd, VEC[i][31:0]);
    end
    busRead(regAddr(1, 1), rd);
    check("R11 high alias left direction bank 1 alone", rd, '0);
    check("R2 pinDir bank 0 follows direction", pinDir[31:0], 32'hA5A5_0F0F);

    // R1: reset clears everything
    doReset();
    check("R1 pinOut after reset", pinOut[95:64], '0);
    check("R1 pinDir after reset", pinDir[31:0], '0);
    busRead(regAddr(4, 1), rd);
    check("R1 rise enable after reset", rd, '0);
    check("R1 notify low", {31'b0, levelReadPulse}, '0);

    // R3: set and clear ports
    busWrite(regAddr(2, 0), 32'h0000_00F0);
    busWrite(regAddr(3, 0), 32'h0000_0030);
    check("R3 set then clear", pinOut[31:0], 32'h0000_00C0);
    busWrite(regAddr(2, 0), 32'h0000_0001);
    check("R3 zero bits unchanged", pinOut[31:0], 32'h0000_00C1);

    // R5 and R10: level merge and notify pulse
    busWrite(regAddr(1, 0), 32'h0000_00FF);
    pinIn[31:0] = 32'hFFFF_0F0F;
    waitCycles(3);
    busRead(regAddr(0, 0), rd);
    check("R5 level merge", rd, 32'hFFFF_0FC1);
    check("R10 notify high", {31'b0, levelReadPulse}, 32'd1);
    @(negedge clk); #1;
    check("R10 notify single cycle", {31'b0, levelReadPulse}, '0);
    busRead(regAddr(1, 0), rd);
    check("R10 no notify on direction read", {31'b0, levelReadPulse}, '0);

    // R6 and R8: rising edge on pin 0 with latency
    doReset();
    busWrite(regAddr(4, 0), 32'h0000_0001);
    pinIn[0] = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    check("R6 no status before third edge", {31'b0, irqPin0}, '0);
    @(negedge clk); #1;
    check("R6 R8 rise sets irqPin0", {31'b0, irqPin0}, 32'd1);
    pinIn[1] = 1'b1;
    waitCycles(4);
    check("R6 disabled pin stays clear", {31'b0, irqPin1}, '0);
    busWrite(regAddr(5, 0), 32'h0000_0002);
    pinIn[1] = 1'b0;
    waitCycles(4);
    check("R6 R8 fall sets irqPin1", {31'b0, irqPin1}, 32'd1);
    check("R9 shared stays low", {31'b0, irqShared}, '0);

    // R7: write-one-to-clear and edge wins
    busWrite(regAddr(6, 0), 32'h0000_0001);
    check("R7 clear drops irqPin0", {31'b0, irqPin0}, '0);
    busRead(regAddr(6, 0), rd);
    check("R7 other bit kept", rd, 32'h0000_0002);
    pinIn[0] = 1'b0;
    waitCycles(4);
    pinIn[0] = 1'b1;
    waitCycles(4);
    check("R7 second rise", {31'b0, irqPin0}, 32'd1);
    pinIn[0] = 1'b0;
    waitCycles(4);
    pinIn[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    busWrite(regAddr(6, 0), 32'h0000_0001);
    #1;
    check("R7 edge wins over clear", {31'b0, irqPin0}, 32'd1);
    busWrite(regAddr(6, 0), 32'h0000_0001);
    check("R7 plain clear", {31'b0, irqPin0}, '0);

    // R9: shared interrupt
    busWrite(regAddr(4, 3), 32'h8000_0000);
    busWrite(regAddr(4, 0), 32'h0000_0004);
    pinIn[127] = 1'b1;
    waitCycles(4);
    check("R9 bank 3 pin raises shared", {31'b0, irqShared}, 32'd1);
    pinIn[2] = 1'b1;
    waitCycles(4);
    busWrite(regAddr(6, 3), 32'h8000_0000);
    check("R9 bank 0 pin 2 keeps shared", {31'b0, irqShared}, 32'd1);
    busWrite(regAddr(6, 0), 32'h0000_0004);
    check("R9 shared low when clear", {31'b0, irqShared}, '0);
    check("R8 irqPin1 unaffected", {31'b0, irqPin1}, 32'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule